// File: doc/BRIEF.md
# Multiplexed Bus Address Decoder

This block sits on the processor side of a shared address/data bus and turns one bus cycle into the selects a small memory and port system needs. While the address-phase strobe is high the shared lines carry an address. When the strobe drops they carry data. The block keeps the address in a register across the data phase. That register feeds the module and port decoders.

The register drives two decoders. The upper bits pick one of the 256-byte memory modules through an active-low chip select, and the lower byte goes to every module in parallel. For the separate port space, the lower byte picks one port select line. A compact command set is converted into separate active-low strobes: a read line, a write line, a two-bit space field and a code-fetch flag become memory read, memory write, port read, port write and program fetch. Command combinations that are not legal raise an error flag and drive nothing.

Top module: `mux_bus_decoder`

## Requirements
- R1: While rst_ni is low, addr_o is 0. With rd_ni and wr_ni both high, every strobe output and every chip select is high (inactive), port_sel_o is 0 and err_o is 0.
- R2: addr_o changes only at the clock edge where addr_phase_i is first sampled low after being sampled high. At that edge it takes the value bus_i had at the previous edge, which is the last edge with the strobe high. Bus values driven while the strobe is low are never captured.
- R3: During a memory access (mem_rd_no, mem_wr_no or prog_en_no low), cs_no bit addr_o[11:8] is low and all other bits are high.
- R4: cs_no is all ones whenever none of the three memory strobes is active.
- R5: With space_i = 2'b01 (memory) and code_i = 0, rd_ni low drives mem_rd_no low and wr_ni low drives mem_wr_no low. With space_i = 2'b10 (port space), rd_ni low drives io_rd_no low and wr_ni low drives io_wr_no low. At most one strobe output is low at any time.
- R6: A read with code_i = 1 in memory space drives only prog_en_no low, and mem_rd_no stays high.
- R7: While io_rd_no or io_wr_no is low, port_sel_o bit addr_o[7:0] is 1 if that index is below N_PORTS (16 by default). All other bits are 0. port_sel_o is 0 during memory accesses and when idle.
- R8: A request (rd_ni or wr_ni low) raises err_o and drives every strobe inactive, with no chip or port select, in any of these cases: rd_ni and wr_ni both low; space_i of 2'b00 or 2'b11; code_i = 1 together with a write; code_i = 1 together with port space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 12 | Shared address/data lines |
| addr_phase_i | input | 1 | 1: bus carries address; 0: bus carries data |
| rd_ni | input | 1 | Read command, active low |
| wr_ni | input | 1 | Write command, active low |
| space_i | input | 2 | 01 memory, 10 port space, others invalid |
| code_i | input | 1 | Code fetch flag |
| addr_o | output | 12 | Captured address |
| cs_no | output | 16 | Memory module chip selects, active low |
| port_sel_o | output | 16 | Port selects, active high |
| mem_rd_no | output | 1 | Memory read strobe, active low |
| mem_wr_no | output | 1 | Memory write strobe, active low |
| io_rd_no | output | 1 | Port read strobe, active low |
| io_wr_no | output | 1 | Port write strobe, active low |
| prog_en_no | output | 1 | Program fetch strobe, active low |
| err_o | output | 1 | Illegal command combination |

## Verification
The hardest case to reach from the ports is the capture boundary. The bus switches to a data value in the same cycle the strobe falls, and the strobe stays low for several cycles while the data keeps changing. A wrong capture edge or a transparent register would pick up data instead of the address. The bench drives these sequences directly, with the data phase loaded with values whose upper bits point at a different module. It then runs a long random sweep over the strobe, the bus and all command combinations. The reference model predicts the captured address and every select in every cycle.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  typedef enum logic [1:0] {
    SPACE_NONE = 2'b00,
    SPACE_MEM  = 2'b01,
    SPACE_IO   = 2'b10,
    SPACE_BAD  = 2'b11
  } space_e;

  // decoded commands, active high inside the block
  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic io_rd;
    logic io_wr;
    logic prog;
    logic err;
  } cmd_t;
endpackage

// File: rtl/mbd_addr_latch.sv
module mbd_addr_latch #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_i,
  input  logic              phase_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic              phase_q;
  logic [ADDR_W-1:0] bus_q;
  logic [ADDR_W-1:0] addr_q;
  logic              fall;

  assign fall = phase_q & ~phase_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      bus_q   <= '0;
      addr_q  <= '0;
    end else begin
      phase_q <= phase_i;
      bus_q   <= bus_i;
      if (fall) addr_q <= bus_q;
    end
  end

  assign addr_o = addr_q;

  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall |=> $stable(addr_q));
  // R2
  addr_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> (addr_q == $past(bus_q)));
endmodule

// File: rtl/mbd_cmd_conv.sv
module mbd_cmd_conv
  import mbd_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   rd_ni,
  input  logic   wr_ni,
  input  space_e space_i,
  input  logic   code_i,
  output cmd_t   cmd_o
);
  logic rd, wr, req, both, bad_space, bad_code, ok, in_mem, in_io;

  assign rd        = ~rd_ni;
  assign wr        = ~wr_ni;
  assign req       = rd | wr;
  assign both      = rd & wr;
  assign in_mem    = (space_i == SPACE_MEM);
  assign in_io     = (space_i == SPACE_IO);
  assign bad_space = ~(in_mem | in_io);
  // code fetch is a memory read only
  assign bad_code  = code_i & (wr | in_io);
  assign ok        = req & ~both & ~bad_space & ~bad_code;

  always_comb begin
    cmd_o        = '0;
    cmd_o.err    = req & ~ok;
    cmd_o.mem_rd = ok & in_mem & rd & ~code_i;
    cmd_o.prog   = ok & in_mem & rd &  code_i;
    cmd_o.mem_wr = ok & in_mem & wr;
    cmd_o.io_rd  = ok & in_io  & rd;
    cmd_o.io_wr  = ok & in_io  & wr;
  end

  // R5
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({cmd_o.mem_rd, cmd_o.mem_wr, cmd_o.io_rd, cmd_o.io_wr, cmd_o.prog}) <= 1);
  // R6
  code_no_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o.prog |-> !cmd_o.mem_rd);
  // R8
  rdwr_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_ni && !wr_ni) |-> cmd_o.err);
endmodule

// File: rtl/mbd_sel_decode.sv
module mbd_sel_decode
  import mbd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned OFS_W   = 8,
  parameter int unsigned N_PORTS = 16,
  localparam int unsigned MOD_W  = ADDR_W - OFS_W,
  localparam int unsigned N_MODS = 1 << MOD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  cmd_t               cmd_i,
  output logic [N_MODS-1:0]  cs_no,
  output logic [N_PORTS-1:0] port_sel_o
);
  logic             mem_act, io_act;
  logic [MOD_W-1:0] mod_idx;
  logic [OFS_W-1:0] port_idx;

  assign mem_act  = cmd_i.mem_rd | cmd_i.mem_wr | cmd_i.prog;
  assign io_act   = cmd_i.io_rd | cmd_i.io_wr;
  assign mod_idx  = addr_i[ADDR_W-1:OFS_W];
  assign port_idx = addr_i[OFS_W-1:0];

  for (genvar m = 0; m < N_MODS; m++) begin : g_cs
    assign cs_no[m] = ~(mem_act && (mod_idx == MOD_W'(m)));
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assign port_sel_o[p] = io_act && (port_idx == OFS_W'(p));
  end

  // R3
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));
  // R7
  port_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(port_sel_o));
endmodule

// File: rtl/mux_bus_decoder.sv
module mux_bus_decoder
  import mbd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned OFS_W   = 8,
  parameter int unsigned N_PORTS = 16,
  localparam int unsigned N_MODS = 1 << (ADDR_W - OFS_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  bus_i,
  input  logic               addr_phase_i,
  input  logic               rd_ni,
  input  logic               wr_ni,
  input  logic [1:0]         space_i,
  input  logic               code_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [N_MODS-1:0]  cs_no,
  output logic [N_PORTS-1:0] port_sel_o,
  output logic               mem_rd_no,
  output logic               mem_wr_no,
  output logic               io_rd_no,
  output logic               io_wr_no,
  output logic               prog_en_no,
  output logic               err_o
);
  logic [ADDR_W-1:0] addr;
  cmd_t              cmd;

  mbd_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bus_i   (bus_i),
    .phase_i (addr_phase_i),
    .addr_o  (addr)
  );

  mbd_cmd_conv u_conv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_ni   (rd_ni),
    .wr_ni   (wr_ni),
    .space_i (space_e'(space_i)),
    .code_i  (code_i),
    .cmd_o   (cmd)
  );

  mbd_sel_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .N_PORTS(N_PORTS)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr),
    .cmd_i      (cmd),
    .cs_no      (cs_no),
    .port_sel_o (port_sel_o)
  );

  assign addr_o     = addr;
  assign mem_rd_no  = ~cmd.mem_rd;
  assign mem_wr_no  = ~cmd.mem_wr;
  assign io_rd_no   = ~cmd.io_rd;
  assign io_wr_no   = ~cmd.io_wr;
  assign prog_en_no = ~cmd.prog;
  assign err_o      = cmd.err;

  // R4
  cs_needs_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_no && mem_wr_no && prog_en_no) |-> (&cs_no));
  // R8
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (mem_rd_no && mem_wr_no && io_rd_no && io_wr_no && prog_en_no
               && (&cs_no) && (port_sel_o == '0)));
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ni && wr_ni) |-> (!err_o && (&cs_no) && (port_sel_o == '0)));
endmodule

// File: tb/mux_bus_decoder_bench.sv
module mux_bus_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus = '0;
  logic        phase = 1'b0;
  logic        rd_n = 1'b1, wr_n = 1'b1, code = 1'b0;
  logic [1:0]  space = 2'b00;

  logic [11:0] addr;
  logic [15:0] cs_n, psel;
  logic        mrd_n, mwr_n, iord_n, iowr_n, prog_n, err;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mux_bus_decoder u_mux_bus_decoder (
    .clk_i(clk), .rst_ni(rst_n), .bus_i(bus), .addr_phase_i(phase),
    .rd_ni(rd_n), .wr_ni(wr_n), .space_i(space), .code_i(code),
    .addr_o(addr), .cs_no(cs_n), .port_sel_o(psel),
    .mem_rd_no(mrd_n), .mem_wr_no(mwr_n), .io_rd_no(iord_n),
    .io_wr_no(iowr_n), .prog_en_no(prog_n), .err_o(err)
  );

  // reference model state
  int m_addr = 0, m_busq = 0, m_phq = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr = 0; m_busq = 0; m_phq = 0;
    end else begin
      if (m_phq == 1 && phase == 1'b0) m_addr = m_busq;
      m_busq = bus;
      m_phq  = phase;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit r, w, req, isbad, ok, inmem, inio;
    bit e_mrd, e_mwr, e_ird, e_iwr, e_prog;
    int e_cs, e_ps;
    r = !rd_n; w = !wr_n; req = r || w;
    inmem = (space == 2'b01); inio = (space == 2'b10);
    isbad = (r && w) || !(inmem || inio) || (code && (w || inio));
    ok = req && !isbad;
    e_mrd  = ok && inmem && r && !code;
    e_prog = ok && inmem && r && code;
    e_mwr  = ok && inmem && w;
    e_ird  = ok && inio && r;
    e_iwr  = ok && inio && w;
    e_cs = 16'hffff;
    if (e_mrd || e_mwr || e_prog) e_cs = 16'hffff & ~(1 << ((m_addr >> 8) & 15));
    e_ps = 0;
    if ((e_ird || e_iwr) && (m_addr & 255) < 16) e_ps = 1 << (m_addr & 255);
    chk(addr === 12'(m_addr), (rst_n ? "R2 addr" : "R1 reset addr"), addr, m_addr);
    chk(cs_n === 16'(e_cs), (e_cs != 16'hffff) ? "R3 cs" : "R4 cs idle", cs_n, e_cs);
    chk(psel === 16'(e_ps), "R7 port_sel", psel, e_ps);
    chk(mrd_n === !e_mrd, code ? "R6 mem_rd" : "R5 mem_rd", mrd_n, !e_mrd);
    chk(mwr_n === !e_mwr, "R5 mem_wr", mwr_n, !e_mwr);
    chk(iord_n === !e_ird, "R5 io_rd", iord_n, !e_ird);
    chk(iowr_n === !e_iwr, "R5 io_wr", iowr_n, !e_iwr);
    chk(prog_n === !e_prog, "R6 prog", prog_n, !e_prog);
    chk(err === (req && isbad), "R8 err", err, req && isbad);
  end

  task automatic cyc(input bit ph, input int b, input bit r_n, input bit w_n,
                     input int sp, input bit c);
    @(posedge clk); #1;
    phase = ph; bus = 12'(b); rd_n = r_n; wr_n = w_n; space = 2'(sp); code = c;
  endtask

  // one full bus cycle: address phase, then data phase with a decoy value
  task automatic access(input int a, input int decoy, input bit r_n, input bit w_n,
                        input int sp, input bit c);
    cyc(1, a, 1, 1, sp, c);
    cyc(0, decoy, r_n, w_n, sp, c);      // R2: decoy on the falling cycle
    cyc(0, decoy ^ 12'hf00, r_n, w_n, sp, c);
    cyc(0, decoy + 1, r_n, w_n, sp, c);
    cyc(0, decoy, 1, 1, sp, c);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    access(12'h3a5, 12'hc12, 0, 1, 1, 0);  // R5 memory read
    access(12'hfff, 12'h000, 1, 0, 1, 0);  // R5 memory write, top module
    access(12'h000, 12'hfff, 0, 1, 1, 1);  // R6 code fetch
    access(12'h105, 12'h777, 0, 1, 2, 0);  // R7 port read, port 5
    access(12'h20f, 12'h777, 1, 0, 2, 0);  // R7 port write, port 15
    access(12'h0c8, 12'h003, 1, 0, 2, 0);  // R7 port 200, no select line
    access(12'h4aa, 12'h111, 0, 0, 1, 0);  // R8 rd and wr together
    access(12'h4aa, 12'h111, 0, 1, 0, 0);  // R8 no space
    access(12'h4aa, 12'h111, 1, 0, 3, 0);  // R8 both spaces
    access(12'h4aa, 12'h111, 1, 0, 1, 1);  // R8 code with write
    access(12'h4aa, 12'h111, 0, 1, 2, 1);  // R8 code in port space
    for (int i = 0; i < 4000; i++)
      cyc($urandom_range(0, 1), $urandom, $urandom_range(0, 1), $urandom_range(0, 1),
          $urandom_range(0, 3), $urandom_range(0, 1));
    cyc(0, 0, 1, 1, 1, 0);
    rst_n = 1'b0;                           // R1 async reset mid-run
    @(negedge clk);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    done = 1;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule